// File: doc/BRIEF.md
# Supply Supervisor with Reset Stretch and Freshness Seal

This block follows the state of the main supply from two comparator results that are already synchronous to the clock: one says the supply is below its trip point, the other says it is below the backup battery voltage. From these it drives an active-low processor reset and a recovery-done flag for neighbouring logic. It also drives a battery-backup select and a one-cycle strobe that tells other logic when to capture the memory-organization mode at power-up.

The reset is stretched by a fixed number of clock cycles after the supply becomes valid. Any return below the trip point restarts that count from zero. The recovery-done flag comes up earlier in the same count, so recovery is always complete before the processor leaves reset. A freshness seal keeps backup power off after a cold battery-attach reset until the supply has been valid once. From then on the seal stays armed until the next cold reset.

Top module: `supply_supervisor`

## Requirements
- R1: `rst_out_n` is 0 in every cycle in which `below_trip` is 1, with no clock delay.
- R2: `rst_out_n` becomes 1 only when `below_trip` has been sampled 0 on HOLD_CYC consecutive rising clock edges, and it stays 1 while `below_trip` stays 0.
- R3: A single cycle with `below_trip` at 1 during the hold restarts the full HOLD_CYC count.
- R4: `rec_done` is 1 exactly when `below_trip` is 0 and has been sampled 0 on at least REC_CYC consecutive edges. It drops in the same cycle that `below_trip` returns to 1.
- R5: REC_CYC must be below HOLD_CYC, which is checked at elaboration. `rec_done` is therefore always 1 when `rst_out_n` rises.
- R6: Once the seal is armed, `batt_sel` equals `below_trip` AND `below_batt`.
- R7: While the seal is not armed, `batt_sel` is 0 for every input combination.
- R8: The seal arms at the first rising edge that samples `below_trip` at 0. It then stays armed through any later supply loss until `rst_n` is asserted.
- R9: `mode_stb` is 1 for exactly one cycle: the first cycle in which `below_trip` is 0 after a cycle with `below_trip` at 1, or after reset.
- R10: While `rst_n` is 0, with `below_trip` at 1, all of `rst_out_n`, `rec_done`, `batt_sel` and `mode_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold battery-attach reset, active low |
| below_trip | input | 1 | Supply is below the trip point |
| below_batt | input | 1 | Supply is below the battery voltage |
| rst_out_n | output | 1 | Processor reset, active low |
| rec_done | output | 1 | Recovery time elapsed after a valid supply |
| batt_sel | output | 1 | Select battery as the backup source |
| mode_stb | output | 1 | One-cycle strobe to capture the mode at power-up |

## Verification
The hardest case to reach is a supply dip that lands at each possible point of the hold count, including the last cycle before release. An off-by-one or a counter that is not cleared only shows up at that single position. The bench uses a short hold and sweeps a one-cycle dip across every position of the count, then checks the exact release cycle after each dip. The seal is checked across a cold reset, both before and after the supply has first become valid.

// File: rtl/ssv_pkg.sv
package ssv_pkg;
  // Bits needed to count from 0 up to lim inclusive.
  function automatic int cnt_width(input int lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction

  // Next value of the valid-run counter: cleared on a failure, saturating at lim.
  function automatic int next_run(input int cur, input bit fail, input int lim);
    if (fail) return 0;
    if (cur < lim) return cur + 1;
    return cur;
  endfunction
endpackage

// File: rtl/ssv_hold_timer.sv
module ssv_hold_timer #(
  parameter int HOLD_CYC = 200_000,
  parameter int REC_CYC  = 2_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic below_trip,
  output logic hold_done,
  output logic rec_reached,
  output logic rise_evt
);
  localparam int CW = ssv_pkg::cnt_width(HOLD_CYC);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);
  localparam logic [CW-1:0] REC_V  = CW'(REC_CYC);

  generate
    if (REC_CYC < 1 || REC_CYC >= HOLD_CYC) begin : g_bad_cfg
      $error("recovery count must be at least 1 and below the hold count");
    end
  endgenerate

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= '0;
    else        run_cnt <= CW'(ssv_pkg::next_run(int'(run_cnt), below_trip, HOLD_CYC));
  end

  assign hold_done   = !below_trip && (run_cnt == HOLD_V);
  assign rec_reached = !below_trip && (run_cnt >= REC_V);
  assign rise_evt    = !below_trip && (run_cnt == '0);

  // R1
  fail_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    below_trip |=> (run_cnt == '0));
  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= HOLD_V);
  // R3
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    below_trip |=> !hold_done);
endmodule

// File: rtl/ssv_seal.sv
module ssv_seal (
  input  logic clk,
  input  logic rst_n,
  input  logic below_trip,
  output logic armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           armed <= 1'b0;
    else if (!below_trip) armed <= 1'b1;
  end

  // R8
  seal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor #(
  parameter int HOLD_CYC = 200_000,
  parameter int REC_CYC  = 2_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic below_trip,
  input  logic below_batt,
  output logic rst_out_n,
  output logic rec_done,
  output logic batt_sel,
  output logic mode_stb
);
  logic hold_done, rec_reached, rise_evt, seal_armed;

  ssv_hold_timer #(.HOLD_CYC(HOLD_CYC), .REC_CYC(REC_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .below_trip(below_trip),
    .hold_done(hold_done), .rec_reached(rec_reached), .rise_evt(rise_evt)
  );

  ssv_seal u_seal (
    .clk(clk), .rst_n(rst_n), .below_trip(below_trip), .armed(seal_armed)
  );

  assign rst_out_n = rst_n && hold_done;
  assign rec_done  = rst_n && rec_reached;
  assign batt_sel  = seal_armed && below_trip && below_batt;
  assign mode_stb  = rst_n && rise_evt;

  // R5
  rec_before_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> rec_done);
  // R2
  release_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_out_n && !below_trip) |=> (rst_out_n || below_trip));
  // R9
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_stb |=> !mode_stb);
endmodule

// File: tb/sim_supply_supervisor.sv
module sim_supply_supervisor;
  localparam int CLK_P = 10;
  localparam int HOLD  = 12;
  localparam int REC   = 5;
  localparam int WD    = 20_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bt = 1'b1, bb = 1'b1;
  logic rst_out_n, rec_done, batt_sel, mode_stb;

  int total = 0, bad = 0;
  int run = 0;
  bit armed = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  supply_supervisor #(.HOLD_CYC(HOLD), .REC_CYC(REC)) u0 (
    .clk(clk), .rst_n(rst_n), .below_trip(bt), .below_batt(bb),
    .rst_out_n(rst_out_n), .rec_done(rec_done), .batt_sel(batt_sel), .mode_stb(mode_stb)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, check outputs, then let the edge sample.
  task automatic step(input logic t, input logic b, input string rtag);
    bit e_rst, e_rec, e_bs, e_stb;
    @(negedge clk);
    bt = t; bb = b;
    #1;
    e_rst = !t && (run >= HOLD);
    e_rec = !t && (run >= REC);
    e_bs  = armed && t && b;
    e_stb = !t && (run == 0);
    chk(rst_out_n == e_rst, t ? "R1" : rtag, "rst_out_n", rst_out_n, e_rst);
    chk(rec_done == e_rec, "R4", "rec_done", rec_done, e_rec);
    chk(batt_sel == e_bs, armed ? "R6" : "R7", "batt_sel", batt_sel, e_bs);
    chk(mode_stb == e_stb, "R9", "mode_stb", mode_stb, e_stb);
    if (!t && run == HOLD - 1) // R5: recovery already done one cycle before release
      chk(rec_done == 1'b1 && rst_out_n == 1'b0, "R5", "rec_done before release", rec_done, 1);
    @(posedge clk);
    run = t ? 0 : ((run < HOLD) ? run + 1 : run);
    if (!t) armed = 1'b1;
  endtask

  task automatic cold_reset();
    @(negedge clk);
    rst_n = 1'b0; bt = 1'b1; bb = 1'b1;
    run = 0; armed = 1'b0;
    #1;
    // R10
    chk(!rst_out_n && !rec_done && !batt_sel && !mode_stb, "R10", "outputs in reset",
        {rst_out_n, rec_done, batt_sel, mode_stb}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", WD, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cold_reset();
    // R7: unarmed seal, supply lost in both battery relations
    step(1, 1, "R1"); step(1, 0, "R1"); step(1, 1, "R1");
    // R2/R4/R9 power-up
    for (int i = 0; i < HOLD + 3; i++) step(0, i[0], "R2");
    // R3: sweep a one-cycle dip over every hold position
    for (int p = 1; p <= HOLD; p++) begin
      step(1, p[0], "R1");
      for (int i = 0; i < p; i++) step(0, 1, "R3");
      step(1, 1, "R1");
      for (int i = 0; i < HOLD + 2; i++) step(0, 0, "R3");
    end
    // R6: all battery combinations once armed
    for (int c = 0; c < 4; c++) step(c[1], c[0], "R2");
    // R8: seal survives a long outage
    for (int i = 0; i < 6; i++) step(1, 1, "R1");
    @(negedge clk); #1;
    chk(batt_sel == 1'b1, "R8", "batt_sel after outage", batt_sel, 1);
    // R8/R7: cold reset clears the seal
    cold_reset();
    step(1, 1, "R1");
    chk(batt_sel == 1'b0, "R8", "batt_sel after cold reset", batt_sel, 0);
    for (int i = 0; i < HOLD + 1; i++) step(0, 1, "R2");
    step(1, 1, "R1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule